// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block is the capture engine of a small on-chip logic analyzer. Each clock it joins three probe buses into one sample word and can write that word into a circular sample RAM. A start request arms it. It first fills a programmable number of pre-trigger slots. It then keeps overwriting the ring while it waits for a trigger-hit pulse from a separate trigger unit. After the hit it records exactly enough further samples to fill the ring, then freezes the RAM.

A stop request returns the block to idle from any state. Software reads the state code and the read pointer. It then walks the RAM from the read pointer upward, modulo the depth, which gives the samples in time order with the trigger sample at offset `pretrig_len`. The depth must be a power of two. Only single-shot capture exists.

Top module: `la_capture`

## Requirements
- R1: The sample word is `{probe_c, probe_b, probe_a}`: `probe_a` sits in the low bits and `probe_c` in the high bits. Defaults are 1, 3 and 9 bits, giving a 13-bit word.
- R2: State codes are 0 idle, 1 fill, 2 armed, 3 capturing, 4 captured. A rising edge on `start_req` in idle moves the block to fill on the next clock, or to armed if `pretrig_len` is 0. A start edge in any other state has no effect.
- R3: The block stays in fill for exactly `pretrig_len` cycles and then enters armed. A trigger hit during fill is ignored.
- R4: In armed with no trigger, the block stays armed without limit. It writes one sample per cycle into the ring, and `rd_ptr` advances by one per cycle, starting at 0 on entry.
- R5: A trigger hit in armed writes the trigger sample and holds `rd_ptr`. The block then spends exactly DEPTH−`pretrig_len`−1 cycles in capturing before it enters captured. When `pretrig_len` is DEPTH−1 it goes straight from armed to captured.
- R6: In captured the RAM and `rd_ptr` do not change. Reading address `rd_ptr`+i returns the sample taken i−`pretrig_len` cycles from the trigger cycle, for i from 0 to DEPTH−1.
- R7: A rising edge on `stop_req` sends the block to idle on the next clock and clears `rd_ptr`, from any state. It wins over a start edge in the same cycle.
- R8: `pretrig_len` is latched at the start edge. Later changes to it do not affect the capture in progress.
- R9: `rd_data` holds the RAM word at `rd_addr` one clock after `rd_addr` is applied.
- R10: After reset the state is idle and `rd_ptr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe_a | input | A_W | Probe bus placed in the low sample bits |
| probe_b | input | B_W | Probe bus placed in the middle sample bits |
| probe_c | input | C_W | Probe bus placed in the high sample bits |
| trig_hit | input | 1 | Trigger condition from the trigger unit |
| start_req | input | 1 | Arm request, acted on at its rising edge |
| stop_req | input | 1 | Abort request, acted on at its rising edge |
| pretrig_len | input | log2(DEPTH) | Number of samples kept before the trigger |
| rd_addr | input | log2(DEPTH) | Readout address |
| rd_data | output | A_W+B_W+C_W | Readout word, one cycle latency |
| state | output | 3 | Current state code |
| rd_ptr | output | log2(DEPTH) | Address of the oldest sample in the ring |

## Verification
The hardest cases are at the ends of the pre-trigger range. With a window of DEPTH−1 the trigger cycle itself closes the ring. With a window of 0 the block skips fill. When the wait for the trigger spans more than one trip around the ring, the read pointer has wrapped. The stimulus drives a free-running counter on the probes, so each stored word shows when it was taken. It runs captures with windows of 0, 511, 512 and DEPTH−1, and with armed waits both shorter and longer than the depth. It fires a trigger in the middle of fill and changes `pretrig_len` after the start. It then unrolls the ring from `rd_ptr` and compares every word against counter values relative to the trigger cycle.

// File: rtl/la_capture.sv
`timescale 1ns/1ps
module la_capture #(
  parameter int DEPTH = 1024,
  parameter int A_W = 1,
  parameter int B_W = 3,
  parameter int C_W = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = A_W + B_W + C_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [A_W-1:0] probe_a,
  input  logic [B_W-1:0] probe_b,
  input  logic [C_W-1:0] probe_c,
  input  logic          trig_hit,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic [AW-1:0] pretrig_len,
  input  logic [AW-1:0] rd_addr,
  output logic [SW-1:0] rd_data,
  output logic [2:0]    state,
  output logic [AW-1:0] rd_ptr
);
  localparam logic [2:0] S_IDLE = 3'd0, S_FILL = 3'd1, S_ARMED = 3'd2,
                         S_RUN = 3'd3, S_DONE = 3'd4;

  logic          start_q, stop_q;
  logic [AW-1:0] wr_ptr, pre_q;
  logic [SW-1:0] ring [DEPTH];

  wire           start_rise = start_req & ~start_q;
  wire           stop_rise  = stop_req & ~stop_q;
  wire           writing    = (state == S_FILL) || (state == S_ARMED) || (state == S_RUN);
  wire [AW-1:0]  wr_nxt     = wr_ptr + 1'b1;
  wire           closing    = (wr_nxt == rd_ptr);
  wire [SW-1:0]  sample     = {probe_c, probe_b, probe_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      pre_q   <= '0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= start_req;
      stop_q  <= stop_req;
      if (stop_rise) begin
        state  <= S_IDLE;
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        case (state)
          S_IDLE: if (start_rise) begin
            pre_q  <= pretrig_len;
            wr_ptr <= '0;
            rd_ptr <= '0;
            state  <= (pretrig_len == '0) ? S_ARMED : S_FILL;
          end
          S_FILL: begin
            wr_ptr <= wr_nxt;
            if (wr_nxt == pre_q) state <= S_ARMED;
          end
          S_ARMED: begin
            wr_ptr <= wr_nxt;
            if (trig_hit) state <= closing ? S_DONE : S_RUN;
            else          rd_ptr <= rd_ptr + 1'b1;
          end
          S_RUN: begin
            wr_ptr <= wr_nxt;
            if (closing) state <= S_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (writing) ring[wr_ptr] <= sample;
    rd_data <= ring[rd_addr];
  end
endmodule

// File: rtl/la_capture_chk.sv
`timescale 1ns/1ps
module la_capture_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_req,
  input logic          stop_req,
  input logic [2:0]    state,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [AW-1:0] pre_q
);
  wire [AW-1:0] gap = wr_ptr - rd_ptr;

  assert_stop_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_req) |=> (state == 3'd0 && rd_ptr == '0));

  assert_start_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0 && $rose(start_req) && !$rose(stop_req)) |=> (state == 3'd1 || state == 3'd2));

  assert_fill_no_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd1 && !$rose(stop_req)) |=> (state == 3'd1 || state == 3'd2));

  assert_window_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd2) |-> (gap == pre_q));

  assert_run_holds_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd3 && !$rose(stop_req)) |=> ($stable(rd_ptr) && (state == 3'd3 || state == 3'd4)));

  assert_done_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd4 && !$rose(stop_req)) |=> (state == 3'd4 && $stable(wr_ptr) && $stable(rd_ptr)));
endmodule

bind la_capture la_capture_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
  .state(state), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .pre_q(pre_q)
);

// File: tb/tb_la_capture.sv
`timescale 1ns/1ps
module tb_la_capture;
  localparam int DEPTH = 1024;
  localparam int AW = 10;
  localparam int SW = 13;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, trig, start, stop;
  logic [AW-1:0] pre, rd_addr;
  logic [SW-1:0] rd_data;
  logic [2:0]    state;
  logic [AW-1:0] rd_ptr;
  logic [SW-1:0] cnt = '0;
  logic [0:0]    pa;
  logic [2:0]    pb;
  logic [8:0]    pc;

  assign {pc, pb, pa} = cnt;
  always @(negedge clk) cnt <= cnt + 1'b1;

  la_capture dut (
    .clk(clk), .rst_n(rst_n), .probe_a(pa), .probe_b(pb), .probe_c(pc),
    .trig_hit(trig), .start_req(start), .stop_req(stop), .pretrig_len(pre),
    .rd_addr(rd_addr), .rd_data(rd_data), .state(state), .rd_ptr(rd_ptr)
  );

  int checks = 0;
  int errors = 0;
  logic [SW-1:0] exp_q[$];
  logic [AW-1:0] adr_q[$];

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: one word per clock, one cycle after its address was driven
  always @(posedge clk) begin
    logic [SW-1:0] e;
    logic [AW-1:0] a;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      a = adr_q.pop_front();
      if (rd_data != e) $display("  at address %0d", a);
      check(rd_data == e, "R1/R6/R9 readout word", rd_data, e);
    end
  end

  task automatic pulse_stop();
    @(negedge clk) stop = 1'b1;
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic run(int p, bit fill_trig, int arm_wait, bit change_pre);
    int n;
    logic [SW-1:0] vt;
    logic [AW-1:0] rp;
    pre = p[AW-1:0];
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (change_pre) pre = AW'(p + 37);
    check(state == ((p == 0) ? 3'd2 : 3'd1), "R2 start edge", state, (p == 0) ? 2 : 1);
    n = 0;
    while (state == 3'd1) begin
      n++;
      trig = (fill_trig && n == 2);
      @(negedge clk);
    end
    trig = 1'b0;
    check(n == p, change_pre ? "R3/R8 fill length" : "R3 fill length", n, p);
    check(state == 3'd2, "R3 armed after fill", state, 2);
    repeat (arm_wait) @(negedge clk);
    check(state == 3'd2, "R4 waits for trigger", state, 2);
    check(rd_ptr == AW'(arm_wait), "R4 rd_ptr advance", rd_ptr, arm_wait % DEPTH);
    trig = 1'b1;
    @(posedge clk) vt = cnt;
    @(negedge clk) trig = 1'b0;
    n = 0;
    while (state == 3'd3) begin
      n++;
      @(negedge clk);
    end
    check(n == DEPTH - p - 1, "R5 post-trigger length", n, DEPTH - p - 1);
    check(state == 3'd4, "R5 captured", state, 4);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (40) @(negedge clk);
    check(state == 3'd4, "R2/R6 start ignored, captured holds", state, 4);
    rp = rd_ptr;
    check(rp == AW'(arm_wait), "R5 rd_ptr held", rp, arm_wait % DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      rd_addr = rp + AW'(i);
      adr_q.push_back(rp + AW'(i));
      exp_q.push_back(vt - SW'(p) + SW'(i));
    end
    @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R9 readout drained", exp_q.size(), 0);
    pulse_stop();
    check(state == 3'd0 && rd_ptr == '0, "R7 stop from captured", state, 0);
  endtask

  initial begin
    rst_n = 1'b0; trig = 1'b0; start = 1'b0; stop = 1'b0;
    pre = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(state == 3'd0, "R10 reset state", state, 0);
    check(rd_ptr == '0, "R10 reset rd_ptr", rd_ptr, 0);

    run(512, 1'b1, 700, 1'b0);
    run(511, 1'b0, 5, 1'b1);
    run(0, 1'b0, 1500, 1'b0);
    run(DEPTH - 1, 1'b0, 3, 1'b0);

    // stop while armed
    pre = AW'(8);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (20) @(negedge clk);
    check(state == 3'd2, "R4 armed before stop", state, 2);
    pulse_stop();
    check(state == 3'd0 && rd_ptr == '0, "R7 stop from armed", state, 0);

    // stop during fill
    pre = AW'(300);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    pulse_stop();
    check(state == 3'd0, "R7 stop from fill", state, 0);

    // start and stop together: stop wins
    @(negedge clk) begin start = 1'b1; stop = 1'b1; end
    @(negedge clk) begin start = 1'b0; stop = 1'b0; end
    check(state == 3'd0, "R7 stop beats start", state, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule